// File: doc/BRIEF.md
# Masked Sticky Interrupt Aggregator

This block gathers single-cycle event pulses from a set of timers and from up to sixteen DMA channels. Each pulse is held in a sticky status bit until software clears it. It drives two level interrupt lines toward the processor: a DMA line and a main line. Each line stays high for as long as at least one status bit is both pending and enabled.

The DMA side uses one 32-bit word. Its lower half holds per-channel status and its upper half holds per-channel enables. Software clears status by writing ones to the lower half. A write to that word never changes the enable half. The enables are loaded through a separate companion address. The main side has a status register and a plain mask register. Software clears main status by writing ones, and a write of zero clears everything. Main status bit 1 records that the DMA line has a pending enabled source. Timer `i` sets main status bit `9+i`.

Each output line comes from a two-state machine with the states LINE_QUIET and LINE_RAISED. The transition QUIET→RAISED fires on a cycle where the pending term is nonzero. The transition RAISED→QUIET fires on a cycle where it is zero. Each line therefore follows its pending term one clock later. Reads are combinational from `addr`.

Top module: `irq_aggregator`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears DMA status, DMA enables, main status and main mask to zero, and drives `irq_dma` and `irq_main` low.
- R2: A write to address 0xE010 clears every DMA status bit i for which `wdata[i]` is 1 (i in 0..15), and leaves the other status bits as they were.
- R3: A write to 0xE010 never changes the enable half. A write to 0xE020 loads the enables from `wdata[31:16]`. A read of 0xE010 or 0xE020 returns {enables[15:0], status[15:0]}.
- R4: `irq_dma` is high in the cycle after one in which (DMA status AND DMA enables) is nonzero, and low in the cycle after one in which it is zero.
- R5: A nonzero write to 0xF000 clears every main status bit written as 1 and keeps the others.
- R6: A write of 0x00000000 to 0xF000 clears every main status bit.
- R7: Address 0xF010 is the main mask. It reads back the last value written.
- R8: A pulse on `dma_evt[i]` sets DMA status bit i, so channel 2 sets bit 2. A pulse on `timer_evt[i]` sets main status bit 9+i, so timer 0 sets bit 9.
- R9: An event arriving in the same cycle as a clear write to the same bit leaves that bit set. This holds on both the DMA side and the main side.
- R10: `irq_main` is high in the cycle after one in which (main status AND main mask) is nonzero, and low in the cycle after one in which it is zero.
- R11: While (DMA status AND DMA enables) is nonzero, main status bit 1 is set on each clock edge.
- R12: Writes to any other address change no register, and reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 16 | Register address (byte offset) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| dma_evt | input | 16 | Per-channel DMA completion pulses |
| timer_evt | input | N_TMR | Per-timer event pulses |
| irq_dma | output | 1 | DMA interrupt line |
| irq_main | output | 1 | Main interrupt line |

## Verification
The bench builds the block with its default parameters: four timers based at main bit 9, and the DMA summary on main bit 1. Because timers land on bits 9 and 11, the bench can test a partial clear that leaves one timer bit pending. With the summary on bit 1, the bench can enable that bit in the mask and follow a DMA event through both lines. DMA channels 0, 2 and 4 are each exercised with their enable on or off, so a pending but masked channel is shown to keep `irq_dma` low.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] A_DMA_WORD  = 16'hE010;
    localparam logic [ADDR_W-1:0] A_DMA_EN    = 16'hE020;
    localparam logic [ADDR_W-1:0] A_MAIN_STAT = 16'hF000;
    localparam logic [ADDR_W-1:0] A_MAIN_MASK = 16'hF010;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DMA_WORD,
        SEL_DMA_EN,
        SEL_MAIN_STAT,
        SEL_MAIN_MASK
    } reg_sel_e;

    typedef enum logic {
        LINE_QUIET,
        LINE_RAISED
    } line_state_e;
endpackage

// File: rtl/ic_reg_decode.sv
module ic_reg_decode
    import ic_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);
    always_comb begin
        unique case (addr_i)
            A_DMA_WORD:  sel_o = SEL_DMA_WORD;
            A_DMA_EN:    sel_o = SEL_DMA_EN;
            A_MAIN_STAT: sel_o = SEL_MAIN_STAT;
            A_MAIN_MASK: sel_o = SEL_MAIN_MASK;
            default:     sel_o = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/ic_sticky_bank.sv
// Sticky status bits: set has priority over clear and clear-all.
module ic_sticky_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         clr_all_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] kept;

    always_comb begin
        if (clr_all_i) kept = '0;
        else           kept = q_o & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= kept | set_i;
    end
endmodule

// File: rtl/ic_plain_reg.sv
module ic_plain_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end
endmodule

// File: rtl/ic_line_fsm.sv
// Two-state line generator: the output follows the pending term one cycle later.
module ic_line_fsm
    import ic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic line_o
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pending_i)  state_d = LINE_RAISED;
            LINE_RAISED: if (!pending_i) state_d = LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        line_o = (state_q == LINE_RAISED);
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import ic_pkg::*;
#(
    parameter int N_TMR       = 4,
    parameter int TMR_BASE    = 9,
    parameter int DMA_SUM_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [HALF_W-1:0] dma_evt,
    input  logic [N_TMR-1:0]  timer_evt,
    output logic              irq_dma,
    output logic              irq_main
);
    localparam int TMR_TOP = TMR_BASE + N_TMR;

    reg_sel_e          sel;
    logic [HALF_W-1:0] dma_stat, dma_en, dma_clr;
    logic [DATA_W-1:0] main_stat, main_mask, main_set, main_clr;
    logic              dma_pend, main_pend, main_wr, main_clr_all;
    logic              wr_dma_word, wr_dma_en, wr_main_mask;

    ic_reg_decode u_dec (.addr_i(addr), .sel_o(sel));

    always_comb begin
        wr_dma_word  = wr_en && (sel == SEL_DMA_WORD);
        wr_dma_en    = wr_en && (sel == SEL_DMA_EN);
        main_wr      = wr_en && (sel == SEL_MAIN_STAT);
        wr_main_mask = wr_en && (sel == SEL_MAIN_MASK);
        dma_clr      = wr_dma_word ? wdata[HALF_W-1:0] : '0;
        main_clr     = main_wr ? wdata : '0;
        main_clr_all = main_wr && (wdata == '0);
    end

    ic_sticky_bank #(.W(HALF_W)) u_dma_stat (
        .clk(clk), .rst_n(rst_n), .set_i(dma_evt), .clr_i(dma_clr),
        .clr_all_i(1'b0), .q_o(dma_stat)
    );

    ic_plain_reg #(.W(HALF_W)) u_dma_en (
        .clk(clk), .rst_n(rst_n), .load_i(wr_dma_en),
        .d_i(wdata[DATA_W-1:HALF_W]), .q_o(dma_en)
    );

    assign dma_pend = |(dma_stat & dma_en);

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_main_src
            if (b >= TMR_BASE && b < TMR_TOP && b == DMA_SUM_BIT) begin : g_both
                assign main_set[b] = timer_evt[b-TMR_BASE] | dma_pend;
            end else if (b >= TMR_BASE && b < TMR_TOP) begin : g_tmr
                assign main_set[b] = timer_evt[b-TMR_BASE];
            end else if (b == DMA_SUM_BIT) begin : g_dma
                assign main_set[b] = dma_pend;
            end else begin : g_none
                assign main_set[b] = 1'b0;
            end
        end
    endgenerate

    ic_sticky_bank #(.W(DATA_W)) u_main_stat (
        .clk(clk), .rst_n(rst_n), .set_i(main_set), .clr_i(main_clr),
        .clr_all_i(main_clr_all), .q_o(main_stat)
    );

    ic_plain_reg #(.W(DATA_W)) u_main_mask (
        .clk(clk), .rst_n(rst_n), .load_i(wr_main_mask),
        .d_i(wdata), .q_o(main_mask)
    );

    assign main_pend = |(main_stat & main_mask);

    ic_line_fsm u_dma_line  (.clk(clk), .rst_n(rst_n), .pending_i(dma_pend),  .line_o(irq_dma));
    ic_line_fsm u_main_line (.clk(clk), .rst_n(rst_n), .pending_i(main_pend), .line_o(irq_main));

    always_comb begin
        unique case (sel)
            SEL_DMA_WORD,
            SEL_DMA_EN:    rdata = {dma_en, dma_stat};
            SEL_MAIN_STAT: rdata = main_stat;
            SEL_MAIN_MASK: rdata = main_mask;
            default:       rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import ic_pkg::*;
#(
    parameter int N_TMR       = 4,
    parameter int TMR_BASE    = 9,
    parameter int DMA_SUM_BIT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [HALF_W-1:0] dma_evt,
    input logic [N_TMR-1:0]  timer_evt,
    input logic              irq_dma,
    input logic              irq_main,
    input logic [HALF_W-1:0] dma_stat,
    input logic [HALF_W-1:0] dma_en,
    input logic [DATA_W-1:0] main_stat,
    input logic [DATA_W-1:0] main_mask
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (dma_stat == '0 && dma_en == '0 && main_stat == '0 &&
                    main_mask == '0 && !irq_dma && !irq_main));

    p_dma_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DMA_WORD) |=>
        ((dma_stat & $past(wdata[HALF_W-1:0] & ~dma_evt)) == '0));

    p_en_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DMA_WORD) |=> $stable(dma_en));

    p_dma_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_dma == (|$past(dma_stat & dma_en))));

    p_main_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MAIN_STAT && wdata == '0 && timer_evt == '0 &&
         (dma_stat & dma_en) == '0) |=> (main_stat == '0));

    p_tmr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timer_evt[0] |=> main_stat[TMR_BASE]);

    p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|dma_evt) |=> ((dma_stat & $past(dma_evt)) == $past(dma_evt)));

    p_main_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_main == (|$past(main_stat & main_mask))));

    p_dma_summary_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_stat & dma_en) != '0) |=> main_stat[DMA_SUM_BIT]);
endmodule

bind irq_aggregator irq_aggregator_chk #(
    .N_TMR(N_TMR), .TMR_BASE(TMR_BASE), .DMA_SUM_BIT(DMA_SUM_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dma_evt(dma_evt), .timer_evt(timer_evt), .irq_dma(irq_dma),
    .irq_main(irq_main), .dma_stat(dma_stat), .dma_en(dma_en),
    .main_stat(main_stat), .main_mask(main_mask)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [15:0] waddr;
        logic [31:0] wdat;
        logic [15:0] devt;
        logic [3:0]  tevt;
        logic [15:0] raddr;
        logic [31:0] exp;
        logic        e_dma;
        logic        e_main;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  1'b0, 16'h0000, 32'h0,         16'h0000, 4'h0, 16'hE010, 32'h00000000, 1'b0, 1'b0}, // R1
        '{4'd3,  1'b1, 16'hE020, 32'h00040000, 16'h0000, 4'h0, 16'hE010, 32'h00040000, 1'b0, 1'b0}, // R3
        '{4'd8,  1'b0, 16'h0000, 32'h0,         16'h0004, 4'h0, 16'hE010, 32'h00040004, 1'b1, 1'b0}, // R8
        '{4'd7,  1'b1, 16'hF010, 32'h00000202, 16'h0000, 4'h0, 16'hF010, 32'h00000202, 1'b1, 1'b1}, // R7
        '{4'd11, 1'b0, 16'h0000, 32'h0,         16'h0000, 4'h0, 16'hF000, 32'h00000002, 1'b1, 1'b1}, // R11
        '{4'd4,  1'b0, 16'h0000, 32'h0,         16'h0010, 4'h0, 16'hE010, 32'h00040014, 1'b1, 1'b1}, // R4
        '{4'd3,  1'b1, 16'hE010, 32'hFFFF0010, 16'h0000, 4'h0, 16'hE010, 32'h00040004, 1'b1, 1'b1}, // R3
        '{4'd2,  1'b1, 16'hE010, 32'h00000004, 16'h0000, 4'h0, 16'hE010, 32'h00040000, 1'b0, 1'b1}, // R2
        '{4'd5,  1'b1, 16'hF000, 32'h00000002, 16'h0000, 4'h0, 16'hF000, 32'h00000000, 1'b0, 1'b0}, // R5
        '{4'd8,  1'b0, 16'h0000, 32'h0,         16'h0000, 4'h1, 16'hF000, 32'h00000200, 1'b0, 1'b1}, // R8
        '{4'd8,  1'b0, 16'h0000, 32'h0,         16'h0000, 4'h4, 16'hF000, 32'h00000A00, 1'b0, 1'b1}, // R8
        '{4'd10, 1'b1, 16'hF000, 32'h00000200, 16'h0000, 4'h0, 16'hF000, 32'h00000800, 1'b0, 1'b0}, // R10
        '{4'd6,  1'b1, 16'hF000, 32'h00000000, 16'h0000, 4'h0, 16'hF000, 32'h00000000, 1'b0, 1'b0}, // R6
        '{4'd8,  1'b0, 16'h0000, 32'h0,         16'h0000, 4'h1, 16'hF000, 32'h00000200, 1'b0, 1'b1}, // R8
        '{4'd9,  1'b1, 16'hF000, 32'h00000200, 16'h0000, 4'h1, 16'hF000, 32'h00000200, 1'b0, 1'b1}, // R9
        '{4'd12, 1'b1, 16'h0100, 32'hFFFFFFFF, 16'h0000, 4'h0, 16'h0100, 32'h00000000, 1'b0, 1'b1}, // R12
        '{4'd12, 1'b0, 16'h0000, 32'h0,         16'h0000, 4'h0, 16'hF010, 32'h00000202, 1'b0, 1'b1}, // R12
        '{4'd12, 1'b0, 16'h0000, 32'h0,         16'h0000, 4'h0, 16'hE010, 32'h00040000, 1'b0, 1'b1}, // R12
        '{4'd9,  1'b1, 16'hE010, 32'h00000001, 16'h0001, 4'h0, 16'hE010, 32'h00040001, 1'b0, 1'b1}, // R9
        '{4'd3,  1'b1, 16'hE020, 32'h00010000, 16'h0000, 4'h0, 16'hE020, 32'h00010001, 1'b1, 1'b1}  // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] dma_evt = '0;
    logic [NT-1:0] timer_evt = '0;
    logic        irq_dma, irq_main;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator #(.N_TMR(NT), .TMR_BASE(9), .DMA_SUM_BIT(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dma_evt(dma_evt), .timer_evt(timer_evt),
        .irq_dma(irq_dma), .irq_main(irq_main)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        addr = 16'hF000;
        #1 check(1, "main status after reset", rdata, 32'h0);
        check(1, "irq_dma after reset", {31'd0, irq_dma}, 32'd0);
        check(1, "irq_main after reset", {31'd0, irq_main}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VEC[i].wr; addr = VEC[i].waddr; wdata = VEC[i].wdat;
            dma_evt = VEC[i].devt; timer_evt = VEC[i].tevt;
            @(negedge clk);
            wr_en = 1'b0; dma_evt = '0; timer_evt = '0; addr = VEC[i].raddr;
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            check(int'(VEC[i].req), $sformatf("vec %0d rdata", i), rdata, VEC[i].exp);
            check(int'(VEC[i].req), $sformatf("vec %0d irq_dma", i), {31'd0, irq_dma}, {31'd0, VEC[i].e_dma});
            check(int'(VEC[i].req), $sformatf("vec %0d irq_main", i), {31'd0, irq_main}, {31'd0, VEC[i].e_main});
        end

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        addr = 16'hE010;
        #1 check(1, "dma word in reset", rdata, 32'h0);
        addr = 16'hF010;
        #1 check(1, "main mask in reset", rdata, 32'h0);
        check(1, "irq_dma in reset", {31'd0, irq_dma}, 32'd0);
        check(1, "irq_main in reset", {31'd0, irq_main}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: one-cycle latency of the DMA line, rise and fall
        @(negedge clk);
        wr_en = 1'b1; addr = 16'hE020; wdata = 32'h0001_0000;
        @(negedge clk);
        wr_en = 1'b0; dma_evt = 16'h0001;
        @(negedge clk);
        dma_evt = '0;
        check(4, "irq_dma in status cycle", {31'd0, irq_dma}, 32'd0);
        @(negedge clk);
        check(4, "irq_dma one cycle later", {31'd0, irq_dma}, 32'd1);
        wr_en = 1'b1; addr = 16'hE010; wdata = 32'h0000_0001;
        @(negedge clk);
        wr_en = 1'b0;
        check(4, "irq_dma in clear cycle", {31'd0, irq_dma}, 32'd1);
        @(negedge clk);
        check(4, "irq_dma after clear", {31'd0, irq_dma}, 32'd0);

        // R11: main status bit 1 was set by the pending DMA source
        addr = 16'hF000;
        #1 check(11, "dma summary bit", rdata & 32'h2, 32'h2);

        // R6: all-zero write wipes several bits at once
        @(negedge clk);
        timer_evt = 4'hF;
        @(negedge clk);
        timer_evt = '0;
        #1 check(8, "all timer bits", rdata, 32'h0000_1E02);
        @(negedge clk);
        wr_en = 1'b1; wdata = 32'h0;
        @(negedge clk);
        wr_en = 1'b0;
        #1 check(6, "zero write clears all", rdata, 32'h0);

        finish_run();
    end
endmodule